// File: doc/BRIEF.md
# Memory Scrubber with Segment Fencing

This block is a background maintenance engine for a memory that is split into equal segments. It has a primary region of `NUM_SEG` segments and a spare region of `NUM_SPARE` segments behind it. On a programmable interval it visits one primary location. It reads the word and takes the 2-bit check status that the memory returns with the data. When the memory reports a corrected error, the engine writes the corrected word back to the same location. An error-detection-and-correction decoder in front of the memory produces that status; the decoder is not part of this block.

Every primary segment has its own saturating error counter. Correctable errors raise it, whether a scrub pass finds them or the host path reports them. When a counter reaches the configured threshold, the engine copies that segment word by word into the next unused spare segment and then fences it. An uncorrectable error fences the segment at once, without the copy. Every new fence raises a one-cycle alert pulse. If no spare segment is left, the segment is fenced without a copy and a sticky no-spare flag is set.

Addresses are `{segment, offset}`, and spare segment k has segment index `NUM_SEG + k`. The memory request channel is valid/ready. Once the engine raises `mem_req_valid`, it holds address, write flag and data stable until `mem_req_ready` is high at a clock edge. An outside arbiter gives host traffic priority by holding `mem_req_ready` low, and this stalls the engine. Read data comes back on a later cycle with `mem_rsp_valid`. That response path has no back-pressure: the engine has at most one read in flight and always accepts the response.

Top module: `mem_scrubber`

## Requirements
- R1: While `cfg_enable` is high, the engine starts one scrub step each time the interval counter passes `cfg_interval` idle cycles. It visits primary locations in ascending address order and wraps from the last one to address 0. While `cfg_enable` is low, it starts no new memory request.
- R2: The scrub read status is 00 for clean, 01 for corrected, and 10 or 11 for uncorrectable. A clean read issues no write. A corrected read issues a write of the returned data to the same address and adds one to that segment's counter.
- R3: An uncorrectable status on a scrub read fences that segment immediately, with no copy and no threshold wait.
- R4: When a segment's counter reaches a non-zero `cfg_threshold` and the segment is not yet fenced, the engine first copies all of its words, in offset order, into the next unused spare segment (segment index `NUM_SEG + k`). After the last copy write it fences the segment. Counters saturate at their maximum value.
- R5: A host report with `host_err_status` 01 adds one to the named segment's counter. A report with bit 1 set fences that segment at once. Reports that name a spare segment, and reports with status 00, change nothing.
- R6: When a segment reaches the threshold and no spare segment is left, it is fenced with no copy, and `no_spare` rises and stays high until reset.
- R7: Fenced segments are never read by scrub steps. Fence bits stay set until reset.
- R8: A pending request keeps `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_wdata` stable until it is accepted. Holding `mem_req_ready` low stalls the engine without losing the step.
- R9: `alert` pulses high for exactly the cycle in which one or more new bits first appear in `fence_mask`, and at no other time.
- R10: After reset, `fence_mask`, `alert`, `no_spare` and `mem_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows new scrub steps |
| cfg_interval | input | INT_W | Idle cycles between scrub steps |
| cfg_threshold | input | CNT_W | Error count that triggers relocation; 0 disables it |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted (host has priority) |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | SEG_W+OFF_W | Request address {segment, offset} |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | DATA_W | Read data, already corrected |
| mem_rsp_status | input | 2 | Check status of the read |
| host_err_valid | input | 1 | Host-path error report strobe |
| host_err_seg | input | SEG_W | Segment named by the host report |
| host_err_status | input | 2 | Status seen by the host access |
| fence_mask | output | NUM_SEG | One bit per fenced primary segment |
| alert | output | 1 | One-cycle pulse on a new fence |
| no_spare | output | 1 | Sticky: a segment was fenced with no spare left |

## Verification
The bench builds the block with four primary segments of four words each, a single spare segment, 2-bit counters, a threshold of 3 and a short interval, so that one scrub pass lasts about a hundred cycles. With these values, one segment can reach the threshold and use up the only spare within a few passes, and a second segment is then forced down the fence-without-copy path that sets `no_spare`. The 2-bit counters also put the saturation limit right next to the threshold.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEEK, ST_RD, ST_RSP, ST_WB, ST_CRD, ST_CRSP, ST_CWR
  } seq_state_e;

  localparam logic [1:0] MST_FIXED = 2'b01;
endpackage

// File: rtl/scrub_tick_timer.sv
module scrub_tick_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [INT_W-1:0] interval,
  output logic             tick
);
  logic [INT_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= interval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seg_err_tracker.sv
module seg_err_tracker #(
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = 3,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   thr,
  input  logic               scrub_inc,
  input  logic [SEG_W-1:0]   scrub_seg,
  input  logic               host_inc,
  input  logic               host_fence,
  input  logic [SEG_W-1:0]   host_seg,
  input  logic               fence_req,
  input  logic [SEG_W-1:0]   fence_seg,
  output logic [NUM_SEG-1:0] fenced,
  output logic               alert,
  output logic               pend,
  output logic [SEG_W-1:0]   pend_seg
);
  logic [NUM_SEG-1:0] set_v;
  logic [NUM_SEG-1:0] pend_v;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             hit_s, hit_h;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    assign hit_s = scrub_inc && (scrub_seg == SEG_W'(g));
    assign hit_h = host_inc && (host_seg == SEG_W'(g));
    assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(hit_s) + (CNT_W+1)'(hit_h);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    assign set_v[g]  = (fence_req && (fence_seg == SEG_W'(g))) ||
                       (host_fence && (host_seg == SEG_W'(g)));
    assign pend_v[g] = (thr != '0) && (cnt_q >= thr) && !fenced[g];
  end

  always_comb begin
    pend_seg = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--)
      if (pend_v[i]) pend_seg = SEG_W'(i);
  end
  assign pend = |pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fenced <= '0;
      alert  <= 1'b0;
    end else begin
      fenced <= fenced | set_v;
      alert  <= |(set_v & ~fenced);
    end
  end
endmodule

// File: rtl/scrub_sequencer.sv
module scrub_sequencer
  import scrub_pkg::*;
#(
  parameter int NUM_SEG   = 4,
  parameter int NUM_SPARE = 2,
  parameter int SEG_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int SEG_W     = 3,
  parameter int OFF_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  output logic                   idle,
  input  logic [NUM_SEG-1:0]     fenced,
  input  logic                   pend,
  input  logic [SEG_W-1:0]       pend_seg,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic                   req_write,
  output logic [SEG_W+OFF_W-1:0] req_addr,
  output logic [DATA_W-1:0]      req_wdata,
  input  logic                   rsp_valid,
  input  logic [DATA_W-1:0]      rsp_data,
  input  logic [1:0]             rsp_status,
  output logic                   scrub_inc,
  output logic [SEG_W-1:0]       scrub_seg,
  output logic                   fence_req,
  output logic [SEG_W-1:0]       fence_seg,
  output logic                   no_spare
);
  localparam int SP_W = $clog2(NUM_SPARE + 1);
  localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(NUM_SEG - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SEG_WORDS - 1);

  seq_state_e        state;
  logic [SEG_W-1:0]  ptr_seg, cp_seg, nxt_seg, adv_seg, spare_seg;
  logic [OFF_W-1:0]  ptr_off, cp_idx, adv_off;
  logic [SP_W-1:0]   used;
  logic [DATA_W-1:0] wbuf;
  logic              spare_left, cur_fenced;

  assign nxt_seg    = (ptr_seg == LAST_SEG) ? '0 : ptr_seg + 1'b1;
  assign adv_seg    = (ptr_off == LAST_OFF) ? nxt_seg : ptr_seg;
  assign adv_off    = (ptr_off == LAST_OFF) ? '0 : ptr_off + 1'b1;
  assign spare_seg  = SEG_W'(NUM_SEG) + SEG_W'(used);
  assign spare_left = used < SP_W'(NUM_SPARE);
  assign cur_fenced = |(fenced & (NUM_SEG'(1) << ptr_seg));

  assign idle      = (state == ST_IDLE);
  assign req_valid = (state == ST_RD) || (state == ST_WB) ||
                     (state == ST_CRD) || (state == ST_CWR);
  assign req_write = (state == ST_WB) || (state == ST_CWR);
  assign req_wdata = wbuf;
  assign scrub_seg = ptr_seg;
  assign scrub_inc = (state == ST_RSP) && rsp_valid && (rsp_status == MST_FIXED);

  always_comb begin
    case (state)
      ST_CRD:  req_addr = {cp_seg, cp_idx};
      ST_CWR:  req_addr = {spare_seg, cp_idx};
      default: req_addr = {ptr_seg, ptr_off};
    endcase
  end

  always_comb begin
    fence_req = 1'b0;
    fence_seg = '0;
    if (state == ST_IDLE && pend && !spare_left) begin
      fence_req = 1'b1;
      fence_seg = pend_seg;
    end else if (state == ST_RSP && rsp_valid && rsp_status[1]) begin
      fence_req = 1'b1;
      fence_seg = ptr_seg;
    end else if (state == ST_CWR && req_ready && cp_idx == LAST_OFF) begin
      fence_req = 1'b1;
      fence_seg = cp_seg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ptr_seg  <= '0;
      ptr_off  <= '0;
      cp_seg   <= '0;
      cp_idx   <= '0;
      used     <= '0;
      wbuf     <= '0;
      no_spare <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pend) begin
            if (spare_left) begin
              cp_seg <= pend_seg;
              cp_idx <= '0;
              state  <= ST_CRD;
            end else begin
              no_spare <= 1'b1;
            end
          end else if (tick) begin
            state <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (&fenced) state <= ST_IDLE;
          else if (cur_fenced) begin
            ptr_seg <= nxt_seg;
            ptr_off <= '0;
          end else state <= ST_RD;
        end
        ST_RD: if (req_ready) state <= ST_RSP;
        ST_RSP: begin
          if (rsp_valid) begin
            if (rsp_status == MST_FIXED) begin
              wbuf  <= rsp_data;
              state <= ST_WB;
            end else begin
              ptr_seg <= adv_seg;
              ptr_off <= adv_off;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WB: begin
          if (req_ready) begin
            ptr_seg <= adv_seg;
            ptr_off <= adv_off;
            state   <= ST_IDLE;
          end
        end
        ST_CRD: if (req_ready) state <= ST_CRSP;
        ST_CRSP: begin
          if (rsp_valid) begin
            wbuf  <= rsp_data;
            state <= ST_CWR;
          end
        end
        ST_CWR: begin
          if (req_ready) begin
            if (cp_idx == LAST_OFF) begin
              used  <= used + 1'b1;
              state <= ST_IDLE;
            end else begin
              cp_idx <= cp_idx + 1'b1;
              state  <= ST_CRD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber #(
  parameter int NUM_SEG   = 4,
  parameter int NUM_SPARE = 2,
  parameter int SEG_WORDS = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 4,
  parameter int INT_W     = 16,
  localparam int SEG_W    = $clog2(NUM_SEG + NUM_SPARE),
  localparam int OFF_W    = $clog2(SEG_WORDS),
  localparam int ADDR_W   = SEG_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [INT_W-1:0]   cfg_interval,
  input  logic [CNT_W-1:0]   cfg_threshold,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  input  logic [1:0]         mem_rsp_status,
  input  logic               host_err_valid,
  input  logic [SEG_W-1:0]   host_err_seg,
  input  logic [1:0]         host_err_status,
  output logic [NUM_SEG-1:0] fence_mask,
  output logic               alert,
  output logic               no_spare
);
  logic             seq_idle, tick, pend, scrub_inc, fence_req;
  logic             host_inc, host_fence;
  logic [SEG_W-1:0] pend_seg, scrub_seg, fence_seg;

  assign host_inc   = host_err_valid && (host_err_status == 2'b01);
  assign host_fence = host_err_valid && host_err_status[1];

  scrub_tick_timer #(.INT_W(INT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(cfg_enable && seq_idle),
    .interval(cfg_interval), .tick(tick)
  );

  seg_err_tracker #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .CNT_W(CNT_W)) track_i (
    .clk(clk), .rst_n(rst_n), .thr(cfg_threshold),
    .scrub_inc(scrub_inc), .scrub_seg(scrub_seg),
    .host_inc(host_inc), .host_fence(host_fence), .host_seg(host_err_seg),
    .fence_req(fence_req), .fence_seg(fence_seg),
    .fenced(fence_mask), .alert(alert), .pend(pend), .pend_seg(pend_seg)
  );

  scrub_sequencer #(
    .NUM_SEG(NUM_SEG), .NUM_SPARE(NUM_SPARE), .SEG_WORDS(SEG_WORDS),
    .DATA_W(DATA_W), .SEG_W(SEG_W), .OFF_W(OFF_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle(seq_idle),
    .fenced(fence_mask), .pend(pend), .pend_seg(pend_seg),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_write(mem_req_write), .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .rsp_status(mem_rsp_status),
    .scrub_inc(scrub_inc), .scrub_seg(scrub_seg),
    .fence_req(fence_req), .fence_seg(fence_seg), .no_spare(no_spare)
  );
endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int NUM_SEG = 4,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic [DATA_W-1:0]  mem_req_wdata,
  input logic [NUM_SEG-1:0] fence_mask,
  input logic               alert,
  input logic               no_spare
);
  // R8: a stalled request is held unchanged
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
      $stable(mem_req_wdata));

  // R7: fence bits never clear while out of reset
  p_fence_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fence_mask & $past(fence_mask)) == $past(fence_mask)));

  // R9: every change of the fence mask comes with an alert
  p_alert_on_fence_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_mask != $past(fence_mask)) |-> alert);

  // R9: no alert without a new fence bit
  p_alert_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (fence_mask != $past(fence_mask)));

  // R6: the no-spare flag stays high once raised
  p_no_spare_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    no_spare |=> no_spare);
endmodule

bind mem_scrubber scrub_checker #(
  .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .fence_mask(fence_mask),
  .alert(alert), .no_spare(no_spare)
);

// File: tb/mem_scrubber_tb_top.sv
module mem_scrubber_tb_top;
  localparam int NUM_SEG = 4, NUM_SPARE = 1, SEG_WORDS = 4, DATA_W = 32;
  localparam int CNT_W = 2, INT_W = 8;
  localparam int SEG_W  = $clog2(NUM_SEG + NUM_SPARE);
  localparam int OFF_W  = $clog2(SEG_WORDS);
  localparam int ADDR_W = SEG_W + OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PRIM   = NUM_SEG * SEG_WORDS;

  // vector: {addr[11:7], status[6:5], expect write-back[4], expect fence mask[3:0]}
  localparam int NVEC = 5;
  localparam logic [11:0] VEC [NVEC] = '{
    {5'd6,  2'b01, 1'b1, 4'b0000},
    {5'd8,  2'b00, 1'b0, 4'b0000},
    {5'd7,  2'b01, 1'b1, 4'b0000},
    {5'd13, 2'b10, 1'b0, 4'b1000},
    {5'd4,  2'b01, 1'b1, 4'b1010}
  };

  logic               clk = 1'b0, rst_n = 1'b0;
  logic               cfg_enable = 1'b0;
  logic [INT_W-1:0]   cfg_interval = 8'd3;
  logic [CNT_W-1:0]   cfg_threshold = 2'd3;
  logic               mem_req_valid, mem_req_ready, mem_req_write;
  logic [ADDR_W-1:0]  mem_req_addr;
  logic [DATA_W-1:0]  mem_req_wdata;
  logic               mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0]  mem_rsp_data = '0;
  logic [1:0]         mem_rsp_status = 2'b00;
  logic               host_err_valid = 1'b0;
  logic [SEG_W-1:0]   host_err_seg = '0;
  logic [1:0]         host_err_status = 2'b00;
  logic [NUM_SEG-1:0] fence_mask;
  logic               alert, no_spare;
  logic               stall = 1'b0;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wr_last [DEPTH];
  logic [1:0]        inj [DEPTH];
  int                rd_cnt [DEPTH];
  int                wr_cnt [DEPTH];
  int                acc_total = 0;
  int                alerts = 0;
  int                checks = 0, failures = 0;

  always #5 clk = ~clk;
  assign mem_req_ready = !stall;

  mem_scrubber #(
    .NUM_SEG(NUM_SEG), .NUM_SPARE(NUM_SPARE), .SEG_WORDS(SEG_WORDS),
    .DATA_W(DATA_W), .CNT_W(CNT_W), .INT_W(INT_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_interval(cfg_interval),
    .cfg_threshold(cfg_threshold), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_status(mem_rsp_status), .host_err_valid(host_err_valid),
    .host_err_seg(host_err_seg), .host_err_status(host_err_status),
    .fence_mask(fence_mask), .alert(alert), .no_spare(no_spare)
  );

  function automatic logic [DATA_W-1:0] golden(input int a);
    return 32'hA500_0000 | DATA_W'(a);
  endfunction

  // memory model: one-cycle read latency, status injected per address
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (alert) alerts <= alerts + 1;
      if (mem_req_valid && mem_req_ready) begin
        acc_total <= acc_total + 1;
        if (mem_req_write) begin
          mem[mem_req_addr]     <= mem_req_wdata;
          wr_last[mem_req_addr] <= mem_req_wdata;
          wr_cnt[mem_req_addr]  <= wr_cnt[mem_req_addr] + 1;
        end else begin
          mem_rsp_valid  <= 1'b1;
          mem_rsp_data   <= mem[mem_req_addr];
          mem_rsp_status <= inj[mem_req_addr];
          inj[mem_req_addr]    <= 2'b00;
          rd_cnt[mem_req_addr] <= rd_cnt[mem_req_addr] + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic host_report(input int seg, input logic [1:0] st);
    @(negedge clk);
    host_err_valid  = 1'b1;
    host_err_seg    = SEG_W'(seg);
    host_err_status = st;
    @(negedge clk);
    host_err_valid  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int seg_rd [NUM_SEG];
    for (int a = 0; a < DEPTH; a++) begin
      mem[a]     <= (a < PRIM) ? golden(a) : '0;
      wr_last[a] <= '0;
      inj[a]     <= 2'b00;
      rd_cnt[a]  <= 0;
      wr_cnt[a]  <= 0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "fence_mask in reset", fence_mask, 0);
    chk("R10", "alert in reset", alert, 0);
    chk("R10", "no_spare in reset", no_spare, 0);
    chk("R10", "req_valid in reset", mem_req_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1", "requests while disabled", acc_total, 0);
    cfg_enable = 1'b1;

    // table-driven scrub vectors
    for (int v = 0; v < NVEC; v++) begin
      int a, base_rd, base_wr, guard;
      string tag;
      a = int'(VEC[v][11:7]);
      tag = (v == 4) ? "R4" : (VEC[v][6] ? "R3" : "R2");
      base_rd = rd_cnt[a];
      base_wr = wr_cnt[a];
      inj[a] <= VEC[v][6:5];
      guard = 0;
      while (rd_cnt[a] == base_rd && guard < 3000) begin
        @(negedge clk);
        guard++;
      end
      chk("R1", "scrub reached address", longint'(guard < 3000), 1);
      repeat (60) @(negedge clk);
      chk(tag, "write-back count", wr_cnt[a] - base_wr, longint'(VEC[v][4]));
      if (VEC[v][4]) chk("R2", "write-back data", wr_last[a], golden(a));
      chk(tag, "fence_mask", fence_mask, VEC[v][3:0]);
    end
    chk("R9", "alert pulses after two fences", alerts, 2);
    chk("R6", "no_spare with spare left", no_spare, 0);
    for (int i = 0; i < SEG_WORDS; i++)
      chk("R4", "spare copy word", mem[PRIM + i], golden(SEG_WORDS + i));

    // host-path correctable errors on segment 2 reach threshold, no spare left
    for (int k = 0; k < 3; k++) host_report(2, 2'b01);
    repeat (10) @(negedge clk);
    chk("R5", "host errors fence segment 2", fence_mask, 4'b1110);
    chk("R6", "no_spare raised", no_spare, 1);
    chk("R9", "alert pulses after three fences", alerts, 3);
    for (int i = 0; i < SEG_WORDS; i++)
      chk("R6", "no extra spare write", wr_cnt[PRIM + i], 1);

    // reports naming a spare segment or clean status are ignored
    host_report(NUM_SEG, 2'b10);
    host_report(0, 2'b00);
    repeat (10) @(negedge clk);
    chk("R5", "ignored reports keep mask", fence_mask, 4'b1110);
    chk("R5", "ignored reports raise no alert", alerts, 3);

    // fenced segments are skipped
    for (int s = 0; s < NUM_SEG; s++) begin
      seg_rd[s] = 0;
      for (int o = 0; o < SEG_WORDS; o++) seg_rd[s] -= rd_cnt[s*SEG_WORDS + o];
    end
    repeat (300) @(negedge clk);
    for (int s = 0; s < NUM_SEG; s++)
      for (int o = 0; o < SEG_WORDS; o++) seg_rd[s] += rd_cnt[s*SEG_WORDS + o];
    chk("R1", "live segment scrubbed", longint'(seg_rd[0] >= SEG_WORDS), 1);
    for (int s = 1; s < NUM_SEG; s++)
      chk("R7", "fenced segment reads", seg_rd[s], 0);

    // back-pressure: host holds the port
    begin
      int guard, bad, acc0;
      logic [ADDR_W-1:0] cap;
      stall = 1'b1;
      guard = 0;
      while (!mem_req_valid && guard < 500) begin
        @(negedge clk);
        guard++;
      end
      cap = mem_req_addr;
      acc0 = acc_total;
      bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (!mem_req_valid || mem_req_addr != cap) bad++;
      end
      chk("R8", "request held during stall", bad, 0);
      chk("R8", "nothing accepted during stall", acc_total - acc0, 0);
      stall = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8", "request accepted after stall", longint'(acc_total > acc0), 1);
    end

    // disabling stops new steps
    begin
      int acc0;
      cfg_enable = 1'b0;
      repeat (20) @(negedge clk);
      acc0 = acc_total;
      repeat (100) @(negedge clk);
      chk("R1", "no requests when disabled", acc_total - acc0, 0);
    end

    // reset clears sticky state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7", "fence bits cleared by reset", fence_mask, 0);
    chk("R10", "no_spare cleared by reset", no_spare, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule